// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit timer that produces one symmetric pulse-width-modulated output. Its counter ramps up from zero to its maximum value and then back down to zero, over and over. It moves one step only on cycles where the timer-clock enable input is high. Each step ends on a new count value, and that value is compared against an active compare value. A match reached while climbing drives the waveform low. A match reached while descending drives it high. Each high pulse is therefore centred on the bottom of the ramp, which suits motor-drive and other phase-sensitive loads.

A host programs the block through a simple write port. The host writes the compare value into a holding register, and the timer copies it into the active compare value only at the top of the ramp. A two-bit output-mode field selects what reaches the pin: the port data bit, the non-inverted waveform, or the inverted waveform. A port-direction bit enables the pin driver. Two flags report events and stay set until the host clears them. The bottom flag is set each time the ramp reaches zero. The match flag is set each time the count equals the active compare value.

Top module: `pcpwm_timer`

## Requirements
- R1: With the enable held high, the count goes 0,1,…,254,255,254,…,1,0,1,… Every value, including 255 and 0, lasts for exactly one step, so one period is 510 steps.
- R2: On a cycle where `tick_en` is low, the count, the direction, the waveform and the flags do not change.
- R3: In non-inverted mode (mode field 2) with compare value C and 0 < C < 255, the output is high after a step up to count c when c < C. After a step down to count c, it is high when c <= C. This gives 2*C high steps per period.
- R4: In non-inverted mode, a compare value of 0 gives a constant low output and a value of 255 gives a constant high output, from the second ramp top after the value is written.
- R5: Mode field 3 drives the pin with the complement of the mode-2 waveform.
- R6: With mode field 0 or 1, the pin carries the port data bit (address 2, bit 0) and not the waveform.
- R7: `pwm_oe` is high exactly when the port direction bit (address 2, bit 1) is 1.
- R8: A write to the compare holding register (address 1) has no effect on the waveform until the count next steps up to 255. That step still uses the old value, and every later step uses the new value.
- R9: The bottom flag (`ovf_flag`) is set on the step that reaches count 0. It stays set until the host writes 1 to address 3, bit 0. If a set and a clear fall on the same cycle, the set wins.
- R10: The match flag (`cmp_flag`) is set on the step that reaches the active compare value. It stays set until the host writes 1 to address 3, bit 1.
- R11: After a synchronous reset, the count is 0 and the counter is climbing. The flags, the mode field, the port data and direction bits, and both compare registers are all 0.
- R12: The output-mode field is written through address 0, bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable; one counter step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1 compare, 2 port, 3 flag clear) |
| wr_data | input | 8 | Register write data |
| pwm_pin | output | 1 | Pin value: waveform or port data |
| pwm_oe | output | 1 | Pin driver enable from the direction bit |
| ovf_flag | output | 1 | Sticky bottom-of-ramp flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| cnt_o | output | 8 | Current counter value |

## Verification
The assertions check the counter's shape on every cycle. Each enabled step moves the count by exactly one. The count turns back at 255 and at 0, and it holds still while the enable is low. They also check that the active compare value changes only on the step that reaches the top, that the flags stay set until cleared, and that each flag rises only where its event belongs. The bench scenarios are needed for the waveform itself: the high-step count per period, its position around the bottom, the two extreme compare values, inversion, the pin-source multiplexing, and the delayed pickup of a compare value written in mid-ramp.

// File: rtl/pcpwm_pkg.sv
// Package: shared encodings for the phase-correct PWM timer.
// Assumes an 8-bit-or-wider write data bus and a two-bit register address.
package pcpwm_pkg;
    typedef enum logic [1:0] {
        OM_PORT0  = 2'd0,
        OM_PORT1  = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } outmode_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_PORT = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_BOT  = 0;
    localparam int FLAG_CMP  = 1;
endpackage

// File: rtl/pcpwm_counter.sv
// Module: up/down ramp counter.
// Counts 0..MAX..0 with one step per enabled cycle; MAX and 0 each last a
// single step. Publishes the value the next step will reach and the
// direction of that step, so that its neighbours can act on the same edge.
module pcpwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         step_up
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_MAX_M1 = CNT_MAX - 1'b1;
    localparam logic [W-1:0] ONE = W'(1);

    logic climbing_q;

    // Purpose: the value the next step reaches, given the current direction.
    always_comb begin
        cnt_nxt = climbing_q ? cnt_q + ONE : cnt_q - ONE;
        step_up = climbing_q;
    end

    // Purpose: advance the count and reverse the direction at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            climbing_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
            if (climbing_q && cnt_nxt == CNT_MAX)
                climbing_q <= 1'b0;
            else if (!climbing_q && cnt_nxt == '0)
                climbing_q <= 1'b1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));
    p_top_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX_M1);
    p_bot_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0) |=> cnt_q == ONE);
endmodule

// File: rtl/pcpwm_wavegen.sv
// Module: compare buffering and waveform register.
// Holds the compare value written by the host and copies it into the active
// register on the step that reaches the top. On a match, the waveform is
// cleared when the step was upward and set when it was downward. The ends
// are forced: 0 gives low and the maximum gives high. Assumes the step
// information arrives from the counter in the same cycle as the tick.
module pcpwm_wavegen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic         step_up,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_act,
    output logic         wave_q,
    output logic         match
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cmp_hold_q;
    logic         load_top;

    // Purpose: detect the top-of-ramp step and a compare match on this step.
    always_comb begin
        load_top = tick && step_up && (cnt_nxt == CNT_MAX);
        match    = tick && (cnt_nxt == cmp_act);
    end

    // Purpose: the host-side holding register for the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_hold_q <= '0;
        else if (cmp_wr)
            cmp_hold_q <= cmp_wdata;
    end

    // Purpose: the active compare value, refreshed only at the ramp top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_act <= '0;
        else if (load_top)
            cmp_act <= cmp_hold_q;
    end

    // Purpose: the non-inverted waveform, changed only on a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (match) begin
            if (cmp_act == CNT_MAX)
                wave_q <= 1'b1;
            else if (cmp_act == '0)
                wave_q <= 1'b0;
            else
                wave_q <= !step_up;
        end
    end

    p_load_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act) |-> $past(tick && step_up && cnt_nxt == CNT_MAX));
    p_wave_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(wave_q));
endmodule

// File: rtl/pcpwm_flags.sv
// Module: sticky event flags.
// Each flag is set by its event pulse and cleared by a host write of 1 to
// its bit. A set and a clear on the same cycle leave the flag set.
module pcpwm_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flag_q
);
    // Purpose: hold the flags, with the set taking priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_i) | set_i;
    end

    p_sticky_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q != '0 && clr_i == '0) |=> (flag_q & $past(flag_q)) == $past(flag_q));
endmodule

// File: rtl/pcpwm_timer.sv
// Module: top of the phase-correct PWM timer.
// Decodes the register write port and selects the pin source from the mode
// field. The pin value is the port data bit in modes 0 and 1, and the
// waveform (complemented in mode 3) in modes 2 and 3. The driver enable
// follows the direction bit. Assumes writes are single-cycle strobes.
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_pin,
    output logic         pwm_oe,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0]         cnt_nxt;
    logic                 step_up;
    logic [W-1:0]         cmp_act;
    logic                 wave_q;
    logic                 match;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flags;
    outmode_e             mode_q;
    logic                 port_data_q;
    logic                 port_dir_q;

    pcpwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .cnt_q  (cnt_o),
        .cnt_nxt(cnt_nxt),
        .step_up(step_up)
    );

    pcpwm_wavegen #(.W(W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .cnt_nxt  (cnt_nxt),
        .step_up  (step_up),
        .cmp_wr   (wr_en && wr_addr == ADDR_CMP),
        .cmp_wdata(wr_data),
        .cmp_act  (cmp_act),
        .wave_q   (wave_q),
        .match    (match)
    );

    // Purpose: route the bottom and match events and the host clear bits.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_BOT] = tick_en && !step_up && (cnt_nxt == '0);
        flag_set[FLAG_CMP] = match;
        flag_clr           = (wr_en && wr_addr == ADDR_FLAG) ?
                             wr_data[NUM_FLAGS-1:0] : '0;
    end

    pcpwm_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .flag_q(flags)
    );

    // Purpose: the mode field and the port data and direction bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= OM_PORT0;
            port_data_q <= 1'b0;
            port_dir_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_MODE)
                mode_q <= outmode_e'(wr_data[1:0]);
            if (wr_addr == ADDR_PORT) begin
                port_data_q <= wr_data[0];
                port_dir_q  <= wr_data[1];
            end
        end
    end

    // Purpose: pick the pin source and drive the outputs.
    always_comb begin
        case (mode_q)
            OM_NONINV: pwm_pin = wave_q;
            OM_INV:    pwm_pin = !wave_q;
            default:   pwm_pin = port_data_q;
        endcase
        pwm_oe   = port_dir_q;
        ovf_flag = flags[FLAG_BOT];
        cmp_flag = flags[FLAG_CMP];
    end

    p_bot_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt_o == '0);
    p_cmp_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> cnt_o == cmp_act);
endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_pin, pwm_oe, ovf_flag, cmp_flag;
    logic [7:0] cnt_o;

    int checks = 0;
    int errors = 0;
    int prev_cnt = 0;
    int mism = 0;
    int highs = 0;

    always #10 clk = ~clk;

    pcpwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_pin(pwm_pin),
        .pwm_oe(pwm_oe), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
        .cnt_o(cnt_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        prev_cnt = int'(cnt_o);
    endtask

    // Waveform level from the requirements (R3, R4).
    function automatic bit lvl(input int v, input bit up, input int c);
        if (v == 255) return 1'b1;
        if (v == 0) return 1'b0;
        return up ? (c < v) : (c <= v);
    endfunction

    task automatic sample(input int v, input bit inv);
        bit up;
        bit e;
        @(negedge clk);
        up = (int'(cnt_o) == prev_cnt + 1);
        e = lvl(v, up, int'(cnt_o)) ^ inv;
        if (pwm_pin !== e) mism++;
        if (pwm_pin === 1'b1) highs++;
        prev_cnt = int'(cnt_o);
    endtask

    task automatic wait_cnt(input int c);
        do @(negedge clk); while (int'(cnt_o) != c);
        prev_cnt = c;
    endtask

    task automatic run_period(input int v, input bit inv, input string req);
        wait_cnt(255);
        wait_cnt(255);
        mism = 0; highs = 0;
        for (int i = 0; i < 510; i++) sample(v, inv);
        chk(mism == 0, req, $sformatf("level mismatches C=%0d", v), mism, 0);
        chk(highs == (inv ? 510 - 2 * v : 2 * v), req,
            $sformatf("high steps C=%0d", v), highs, inv ? 510 - 2 * v : 2 * v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(cnt_o == 8'd0, "R11", "count", cnt_o, 0);
        chk(ovf_flag == 1'b0 && cmp_flag == 1'b0, "R11", "flags", {ovf_flag, cmp_flag}, 0);
        chk(pwm_oe == 1'b0, "R11", "oe", pwm_oe, 0);
        chk(pwm_pin == 1'b0, "R11", "pin", pwm_pin, 0);
    endtask

    task automatic t_ramp();
        int bad = 0;
        int first_act = -1;
        int first_exp = -1;
        rst_n = 1'b1;
        for (int k = 1; k <= 1021; k++) begin
            int p;
            int e;
            @(negedge clk);
            p = k % 510;
            e = (p <= 255) ? p : 510 - p;
            if (int'(cnt_o) != e) begin
                if (bad == 0) begin first_act = cnt_o; first_exp = e; end
                bad++;
            end
        end
        chk(bad == 0, "R1", "ramp sequence", first_act, first_exp);
    endtask

    task automatic t_enable();
        int held;
        @(negedge clk);
        tick_en = 1'b0;
        held = cnt_o;
        repeat (20) @(negedge clk);
        chk(int'(cnt_o) == held, "R2", "count with enable low", cnt_o, held);
        tick_en = 1'b1;
        @(negedge clk);
        chk(int'(cnt_o) == held + 1 || int'(cnt_o) == held - 1, "R2",
            "count after enable", cnt_o, held + 1);
    endtask

    task automatic t_port();
        wr(pcpwm_pkg::ADDR_MODE, 8'd0);
        wr(pcpwm_pkg::ADDR_PORT, 8'b11);
        chk(pwm_pin == 1'b1, "R6", "mode0 data1", pwm_pin, 1);
        chk(pwm_oe == 1'b1, "R7", "oe dir1", pwm_oe, 1);
        wr(pcpwm_pkg::ADDR_MODE, 8'd1);
        wr(pcpwm_pkg::ADDR_PORT, 8'b10);
        chk(pwm_pin == 1'b0, "R6", "mode1 data0", pwm_pin, 0);
        wr(pcpwm_pkg::ADDR_PORT, 8'b01);
        chk(pwm_pin == 1'b1, "R6", "mode1 data1", pwm_pin, 1);
        chk(pwm_oe == 1'b0, "R7", "oe dir0", pwm_oe, 0);
        wr(pcpwm_pkg::ADDR_PORT, 8'b10);
    endtask

    task automatic t_noninv(input int v, input string req);
        wr(pcpwm_pkg::ADDR_MODE, 8'd2);
        wr(pcpwm_pkg::ADDR_CMP, 8'(v));
        run_period(v, 1'b0, req);
    endtask

    task automatic t_invert();
        wr(pcpwm_pkg::ADDR_MODE, 8'd3);
        wr(pcpwm_pkg::ADDR_CMP, 8'd70);
        run_period(70, 1'b1, "R5");
    endtask

    task automatic t_buffer();
        int v = 60;
        wr(pcpwm_pkg::ADDR_MODE, 8'd2);
        wr(pcpwm_pkg::ADDR_CMP, 8'd60);
        wait_cnt(255);
        wait_cnt(255);
        wait_cnt(0);
        wait_cnt(10);
        wr(pcpwm_pkg::ADDR_CMP, 8'd180);
        mism = 0;
        while (int'(cnt_o) != 255) sample(v, 1'b0);
        chk(mism == 0, "R8", "old value before top", mism, 0);
        v = 180; mism = 0;
        for (int i = 0; i < 510; i++) sample(v, 1'b0);
        chk(mism == 0, "R8", "new value after top", mism, 0);
    endtask

    task automatic t_cmp_flag();
        int early = 0;
        wait_cnt(255);
        wr(pcpwm_pkg::ADDR_FLAG, 8'b10);
        while (int'(cnt_o) != 180) begin
            if (cmp_flag) early++;
            @(negedge clk);
        end
        chk(early == 0, "R10", "match flag before match", early, 0);
        chk(cmp_flag == 1'b1, "R10", "match flag at match", cmp_flag, 1);
    endtask

    task automatic t_bot_flag();
        int early = 0;
        wait_cnt(255);
        wr(pcpwm_pkg::ADDR_FLAG, 8'b01);
        while (int'(cnt_o) != 0) begin
            if (ovf_flag) early++;
            @(negedge clk);
        end
        chk(early == 0, "R9", "bottom flag before bottom", early, 0);
        chk(ovf_flag == 1'b1, "R9", "bottom flag at bottom", ovf_flag, 1);
        repeat (5) @(negedge clk);
        chk(ovf_flag == 1'b1, "R9", "bottom flag sticky", ovf_flag, 1);
        wr(pcpwm_pkg::ADDR_FLAG, 8'b01);
        chk(ovf_flag == 1'b0, "R9", "bottom flag cleared", ovf_flag, 0);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp();
        t_enable();
        t_port();           // R6, R7, R12 (mode field at address 0)
        t_noninv(1, "R3");
        t_noninv(128, "R3");
        t_noninv(254, "R3");
        t_noninv(0, "R4");
        t_noninv(255, "R4");
        t_invert();
        t_buffer();
        t_cmp_flag();
        t_bot_flag();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule